// File: doc/BRIEF.md
# Region-Selected Flat Page Table Walker

This block turns 48-bit virtual addresses from a near-memory pointer-chasing engine into physical addresses. It uses a private page table that is separate from the host's. The walk has a fixed shape. The uppermost seven address bits pick an entry in a small on-chip region table, which costs no memory access. That entry gives the base of a flat first-level table in which each 8-byte entry covers 2 MB. The flat entry in turn points at a last-level table of 4 KB pages. A complete walk therefore reads memory exactly twice: one flat entry and one last-level entry. A conventional radix walk needs more reads than that.

Only addresses inside a registered region are translated. A request that falls outside every registered region, or that meets an invalid table entry, returns a fault code instead of an address. The region table is loaded through a simple write port. Table entries are fetched through a single-outstanding request/response memory port. The block keeps one last-translation register: a repeat request for the same 4 KB virtual page is answered in one cycle without a walk. Only one walk is in flight at a time.

Top module: `flat_walker`

## Requirements
- R1: The virtual address is split as region index = va[47:41], flat index = va[40:21], page index = va[20:12] and offset = va[11:0]. On success, resp_pa[11:0] equals the request's offset unchanged.
- R2: A write on the region port (rt_we) stores a valid bit and a flat-table base address for entry rt_idx. Looking up the region table issues no memory read. A request whose region entry is invalid ends with resp_err = 1 and no memory read.
- R3: The first memory read is at the address region base + 8 × flat index. A table entry is 64 bits wide: bit 0 is the valid bit and bits [47:12] are the page-aligned base. If the flat entry is invalid, the walk ends with resp_err = 2 after exactly one read.
- R4: The second read is at the address {flat entry[47:12], 12'h000} + 8 × page index. If that entry is invalid, resp_err = 3. Otherwise resp_pa = {entry[47:12], offset} and resp_err = 0. Both outcomes take exactly two reads.
- R5: mem_req_valid and mem_req_addr stay unchanged until mem_req_ready is seen. After a request is accepted, no new request is raised until mem_rsp_valid returns.
- R6: req_ready is high only while no walk is in progress. resp_valid is a one-cycle pulse, and req_ready is high again in the cycle after it.
- R7: Whenever resp_err is nonzero, resp_pa is zero.
- R8: A successful walk records its virtual page number (va[47:12]) and physical page. A later request with the same va[47:12] raises resp_valid in the cycle right after it is accepted, with no memory read, and returns {recorded page, new offset}.
- R9: A walk that faults leaves the last-translation register unchanged. Any region table write empties it, so the next request walks memory.
- R10: After reset, req_ready = 1, resp_valid = 0 and mem_req_valid = 0, every region entry is invalid, and the last-translation register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 48 | Virtual address to translate |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_pa | output | 48 | Translated physical address (zero on fault) |
| resp_err | output | 2 | 0 ok, 1 region invalid, 2 flat entry invalid, 3 page entry invalid |
| rt_we | input | 1 | Region table write strobe |
| rt_idx | input | 7 | Region entry written |
| rt_valid | input | 1 | Valid bit written |
| rt_base | input | 48 | Flat-table base address written |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Table entry read back |

## Verification
Every one of the 128 regions is programmed, with one region in four left invalid. One address per region is walked, with scattered flat indices, page indices and offsets. The bench's memory model returns entries whose valid bit and base come from a formula of the entry address. The sweep therefore mixes clean walks with faults at each of the three levels, and the read addresses separate correct index placement from shifted or swapped fields. Each address is then repeated on the same page with a new offset. This distinguishes a true one-cycle last-translation hit from a repeated walk and from a stale offset. The extreme index values 0 and all-ones in each field, varying memory stall and latency, and region rewrites that must empty the last-translation register or change a base cover the boundary and ordering cases.

// File: rtl/fwalk_pkg.sv
`timescale 1ns/1ps
package fwalk_pkg;

  typedef enum logic [2:0] {
    WS_IDLE     = 3'd0,
    WS_REGION   = 3'd1,
    WS_RD_FLAT  = 3'd2,
    WS_WT_FLAT  = 3'd3,
    WS_RD_SMALL = 3'd4,
    WS_WT_SMALL = 3'd5,
    WS_DONE     = 3'd6
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_REGION = 2'd1,
    FLT_FLAT   = 2'd2,
    FLT_SMALL  = 2'd3
  } walk_fault_e;

  // bit of a table entry that marks it valid
  localparam int unsigned ENT_VALID_BIT = 0;
  // log2 of the table entry size in bytes
  localparam int unsigned ENT_SHIFT     = 3;

endpackage

// File: rtl/fwalk_region_tbl.sv
`timescale 1ns/1ps
module fwalk_region_tbl #(
  parameter int REG_BITS = 7,
  parameter int PA_W     = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_BITS-1:0] wr_idx,
  input  logic                wr_valid,
  input  logic [PA_W-1:0]     wr_base,
  input  logic [REG_BITS-1:0] rd_idx,
  output logic                rd_valid,
  output logic [PA_W-1:0]     rd_base
);

  localparam int ENTRIES = 1 << REG_BITS;

  logic [ENTRIES-1:0] vld_q;
  logic [PA_W-1:0]    base_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic            sel;
    logic            v_q;
    logic [PA_W-1:0] b_q;

    assign sel = wr_en && (wr_idx == REG_BITS'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (sel) v_q <= wr_valid;
    end

    always_ff @(posedge clk) begin
      if (sel) b_q <= wr_base;
    end

    assign vld_q[g]  = v_q;
    assign base_q[g] = b_q;
  end

  // combinational lookup: no memory traffic for this level
  assign rd_valid = vld_q[rd_idx];
  assign rd_base  = base_q[rd_idx];

  // R2: a write lands in the addressed entry
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid)));

endmodule

// File: rtl/fwalk_ltr.sv
`timescale 1ns/1ps
module fwalk_ltr #(
  parameter int VPN_W = 36,
  parameter int PPN_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);

  logic             vld_q, vld_n;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  logic             load_en;

  assign load_en = fill && !flush;

  always_comb begin
    vld_n = vld_q;
    if (flush)     vld_n = 1'b0;
    else if (fill) vld_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      vpn_q <= fill_vpn;
      ppn_q <= fill_ppn;
    end
  end

  assign hit     = vld_q && (vpn_q == look_vpn);
  assign hit_ppn = ppn_q;

  // R9: a region write empties the register
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  // R8: a fill makes the same page hit next cycle
  a_r8_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ((look_vpn != $past(fill_vpn)) || (hit && hit_ppn == $past(fill_ppn))));

endmodule

// File: rtl/fwalk_fsm.sv
`timescale 1ns/1ps
module fwalk_fsm
  import fwalk_pkg::*;
#(
  parameter int REG_BITS   = 7,
  parameter int FLAT_BITS  = 20,
  parameter int SMALL_BITS = 9,
  parameter int OFS_BITS   = 12,
  parameter int PA_W       = 48,
  parameter int ENTRY_W    = 64,
  parameter int VA_W       = 48,
  parameter int VPN_W      = 36,
  parameter int PPN_W      = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_va,
  output logic                resp_valid,
  output logic [PA_W-1:0]     resp_pa,
  output logic [1:0]          resp_err,
  output logic [REG_BITS-1:0] rgn_idx,
  input  logic                rgn_valid,
  input  logic [PA_W-1:0]     rgn_base,
  output logic [VPN_W-1:0]    look_vpn,
  input  logic                ltr_hit,
  input  logic [PPN_W-1:0]    ltr_ppn,
  output logic                ltr_fill,
  output logic [VPN_W-1:0]    fill_vpn,
  output logic [PPN_W-1:0]    fill_ppn,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [ENTRY_W-1:0]  mem_rsp_data
);

  localparam int FLAT_PAD  = PA_W - FLAT_BITS - ENT_SHIFT;
  localparam int SMALL_PAD = PA_W - SMALL_BITS - ENT_SHIFT;

  walk_state_e st_q, st_n;
  walk_fault_e err_q, err_n;
  logic [VA_W-1:0] va_q;
  logic [PA_W-1:0] ptr_q, ptr_n;
  logic [PA_W-1:0] pa_q, pa_n;
  logic            va_en, ptr_en, res_en, fill_c;

  logic [FLAT_BITS-1:0]  flat_idx;
  logic [SMALL_BITS-1:0] small_idx;
  logic [OFS_BITS-1:0]   ofs;
  logic [PPN_W-1:0]      rsp_ppn;
  logic                  rsp_ok;
  logic [PA_W-1:0]       flat_off, small_off;
  logic                  unused_rsp_bits;

  assign rgn_idx   = va_q[VA_W-1 -: REG_BITS];
  assign flat_idx  = va_q[OFS_BITS+SMALL_BITS +: FLAT_BITS];
  assign small_idx = va_q[OFS_BITS +: SMALL_BITS];
  assign ofs       = va_q[OFS_BITS-1:0];
  assign rsp_ppn   = mem_rsp_data[PA_W-1:OFS_BITS];
  assign rsp_ok    = mem_rsp_data[ENT_VALID_BIT];
  assign unused_rsp_bits = ^{mem_rsp_data[ENTRY_W-1:PA_W], mem_rsp_data[OFS_BITS-1:1]};

  assign flat_off  = {{FLAT_PAD{1'b0}},  flat_idx,  {ENT_SHIFT{1'b0}}};
  assign small_off = {{SMALL_PAD{1'b0}}, small_idx, {ENT_SHIFT{1'b0}}};

  // ---------------- next state ----------------
  always_comb begin
    st_n   = st_q;
    va_en  = 1'b0;
    ptr_en = 1'b0;
    ptr_n  = '0;
    res_en = 1'b0;
    pa_n   = '0;
    err_n  = FLT_NONE;
    fill_c = 1'b0;
    case (st_q)
      WS_IDLE: begin
        if (req_valid) begin
          va_en = 1'b1;
          if (ltr_hit) begin
            res_en = 1'b1;
            pa_n   = {ltr_ppn, req_va[OFS_BITS-1:0]};
            st_n   = WS_DONE;
          end else begin
            st_n = WS_REGION;
          end
        end
      end
      WS_REGION: begin
        if (!rgn_valid) begin
          res_en = 1'b1;
          err_n  = FLT_REGION;
          st_n   = WS_DONE;
        end else begin
          ptr_en = 1'b1;
          ptr_n  = rgn_base;
          st_n   = WS_RD_FLAT;
        end
      end
      WS_RD_FLAT: begin
        if (mem_req_ready) st_n = WS_WT_FLAT;
      end
      WS_WT_FLAT: begin
        if (mem_rsp_valid) begin
          if (!rsp_ok) begin
            res_en = 1'b1;
            err_n  = FLT_FLAT;
            st_n   = WS_DONE;
          end else begin
            ptr_en = 1'b1;
            ptr_n  = {rsp_ppn, {OFS_BITS{1'b0}}};
            st_n   = WS_RD_SMALL;
          end
        end
      end
      WS_RD_SMALL: begin
        if (mem_req_ready) st_n = WS_WT_SMALL;
      end
      WS_WT_SMALL: begin
        if (mem_rsp_valid) begin
          res_en = 1'b1;
          st_n   = WS_DONE;
          if (!rsp_ok) begin
            err_n = FLT_SMALL;
          end else begin
            pa_n   = {rsp_ppn, ofs};
            fill_c = 1'b1;
          end
        end
      end
      WS_DONE: st_n = WS_IDLE;
      default: st_n = WS_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk) begin
    if (va_en)  va_q  <= req_va;
    if (ptr_en) ptr_q <= ptr_n;
    if (res_en) begin
      pa_q  <= pa_n;
      err_q <= err_n;
    end
  end

  // ---------------- outputs ----------------
  assign req_ready     = (st_q == WS_IDLE);
  assign resp_valid    = (st_q == WS_DONE);
  assign resp_pa       = pa_q;
  assign resp_err      = err_q;
  assign look_vpn      = req_va[VA_W-1:OFS_BITS];
  assign ltr_fill      = fill_c;
  assign fill_vpn      = va_q[VA_W-1:OFS_BITS];
  assign fill_ppn      = rsp_ppn;
  assign mem_req_valid = (st_q == WS_RD_FLAT) || (st_q == WS_RD_SMALL);
  assign mem_req_addr  = ptr_q + ((st_q == WS_RD_SMALL) ? small_off : flat_off);

  // ---------------- checks ----------------
  logic [1:0] rd_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         rd_cnt <= 2'd0;
    else if (req_valid && req_ready)                    rd_cnt <= 2'd0;
    else if (mem_req_valid && mem_req_ready && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
  end

  a_r2_region_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err == FLT_REGION) |-> (rd_cnt == 2'd0));

  a_r3_flat_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err == FLT_FLAT) |-> (rd_cnt == 2'd1));

  a_r4_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && (resp_err == FLT_SMALL || (resp_err == FLT_NONE && rd_cnt != 2'd0)))
      |-> (rd_cnt == 2'd2));

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> (!resp_valid && req_ready));

  a_r7_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err != FLT_NONE) |-> (resp_pa == '0));

  a_r8_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ltr_hit) |=> (resp_valid && resp_err == FLT_NONE));

endmodule

// File: rtl/flat_walker.sv
`timescale 1ns/1ps
module flat_walker
  import fwalk_pkg::*;
#(
  parameter int REG_BITS   = 7,
  parameter int FLAT_BITS  = 20,
  parameter int SMALL_BITS = 9,
  parameter int OFS_BITS   = 12,
  parameter int PA_W       = 48,
  parameter int ENTRY_W    = 64
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              req_valid,
  output logic                                              req_ready,
  input  logic [REG_BITS+FLAT_BITS+SMALL_BITS+OFS_BITS-1:0] req_va,
  output logic                                              resp_valid,
  output logic [PA_W-1:0]                                   resp_pa,
  output logic [1:0]                                        resp_err,
  input  logic                                              rt_we,
  input  logic [REG_BITS-1:0]                               rt_idx,
  input  logic                                              rt_valid,
  input  logic [PA_W-1:0]                                   rt_base,
  output logic                                              mem_req_valid,
  input  logic                                              mem_req_ready,
  output logic [PA_W-1:0]                                   mem_req_addr,
  input  logic                                              mem_rsp_valid,
  input  logic [ENTRY_W-1:0]                                mem_rsp_data
);

  localparam int VA_W  = REG_BITS + FLAT_BITS + SMALL_BITS + OFS_BITS;
  localparam int VPN_W = VA_W - OFS_BITS;
  localparam int PPN_W = PA_W - OFS_BITS;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [REG_BITS-1:0] rgn_idx;
  logic                rgn_valid;
  logic [PA_W-1:0]     rgn_base;
  logic [VPN_W-1:0]    look_vpn, fill_vpn;
  logic [PPN_W-1:0]    ltr_ppn, fill_ppn;
  logic                ltr_hit, ltr_fill;

  fwalk_region_tbl #(
    .REG_BITS (REG_BITS),
    .PA_W     (PA_W)
  ) u_rgn (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (rt_we),
    .wr_idx   (rt_idx),
    .wr_valid (rt_valid),
    .wr_base  (rt_base),
    .rd_idx   (rgn_idx),
    .rd_valid (rgn_valid),
    .rd_base  (rgn_base)
  );

  fwalk_ltr #(
    .VPN_W (VPN_W),
    .PPN_W (PPN_W)
  ) u_ltr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .flush    (rt_we),
    .fill     (ltr_fill),
    .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn),
    .look_vpn (look_vpn),
    .hit      (ltr_hit),
    .hit_ppn  (ltr_ppn)
  );

  fwalk_fsm #(
    .REG_BITS   (REG_BITS),
    .FLAT_BITS  (FLAT_BITS),
    .SMALL_BITS (SMALL_BITS),
    .OFS_BITS   (OFS_BITS),
    .PA_W       (PA_W),
    .ENTRY_W    (ENTRY_W),
    .VA_W       (VA_W),
    .VPN_W      (VPN_W),
    .PPN_W      (PPN_W)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .resp_valid    (resp_valid),
    .resp_pa       (resp_pa),
    .resp_err      (resp_err),
    .rgn_idx       (rgn_idx),
    .rgn_valid     (rgn_valid),
    .rgn_base      (rgn_base),
    .look_vpn      (look_vpn),
    .ltr_hit       (ltr_hit),
    .ltr_ppn       (ltr_ppn),
    .ltr_fill      (ltr_fill),
    .fill_vpn      (fill_vpn),
    .fill_ppn      (fill_ppn),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  // R10: idle and quiet straight after reset
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (req_ready && !resp_valid && !mem_req_valid));

endmodule

// File: tb/flat_walker_test.sv
`timescale 1ns/1ps
module flat_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic        resp_valid;
  logic [47:0] resp_pa;
  logic [1:0]  resp_err;
  logic        rt_we = 1'b0;
  logic [6:0]  rt_idx = '0;
  logic        rt_valid = 1'b0;
  logic [47:0] rt_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  flat_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_err(resp_err),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_valid(rt_valid), .rt_base(rt_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_checks = 0;
  int n_errs   = 0;
  int rd_count = 0;
  int rd_base  = 0;
  logic [47:0] addr_log [2];
  bit hold_err = 1'b0;
  bit ovl_err  = 1'b0;

  // bench model of what it wrote
  bit          rgn_ok [128];
  logic [47:0] rgn_bs [128];
  bit          ltr_ok = 1'b0;
  logic [35:0] ltr_vpn = '0;
  logic [35:0] ltr_ppn = '0;

  // table content: a formula of the entry address
  function automatic logic [63:0] mem_fn(input logic [47:0] a);
    logic [63:0] w;
    logic [63:0] ppn;
    w   = {16'h0, a} >> 3;
    ppn = (w * 64'd37 + 64'd11) & 64'hF_FFFF_FFFF;
    return (ppn << 12) | {63'd0, ((w % 64'd7) != 64'd3)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory responder with varying stall and latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [47:0] a0;
        logic [47:0] acap;
        int stall;
        int lat;
        a0    = mem_req_addr;
        stall = rd_count % 3;
        lat   = rd_count % 4;
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          if (!mem_req_valid || mem_req_addr != a0) hold_err = 1'b1;
        end
        mem_req_ready = 1'b1;
        acap = mem_req_addr;
        if (rd_count - rd_base < 2) addr_log[rd_count - rd_base] = acap;
        rd_count++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < lat; i++) begin
          if (mem_req_valid) ovl_err = 1'b1;
          @(negedge clk);
        end
        if (mem_req_valid) ovl_err = 1'b1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_fn(acap);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  task automatic wr_rgn(input int idx, input bit v, input logic [47:0] b);
    @(negedge clk);
    rt_we = 1'b1; rt_idx = 7'(idx); rt_valid = v; rt_base = b;
    @(negedge clk);
    rt_we = 1'b0;
    rgn_ok[idx] = v;
    rgn_bs[idx] = b;
    ltr_ok = 1'b0;   // R9: any region write empties the register
  endtask

  task automatic run(input logic [47:0] va);
    logic [6:0]  r;
    logic [47:0] fa, sa, exp_pa;
    logic [63:0] e1, e2;
    int          exp_err, exp_reads, reads, cyc;
    bit          hit, busy_ok;
    string       etag, rtag;
    r = va[47:41];
    fa = '0; sa = '0; exp_pa = '0; hit = 1'b0;
    if (ltr_ok && va[47:12] == ltr_vpn) begin
      hit = 1'b1; exp_err = 0; exp_reads = 0; exp_pa = {ltr_ppn, va[11:0]};
    end else if (!rgn_ok[r]) begin
      exp_err = 1; exp_reads = 0;
    end else begin
      fa = rgn_bs[r] + {25'd0, va[40:21], 3'd0};
      e1 = mem_fn(fa);
      if (!e1[0]) begin
        exp_err = 2; exp_reads = 1;
      end else begin
        sa = {e1[47:12], 12'h000} + {36'd0, va[20:12], 3'd0};
        e2 = mem_fn(sa);
        exp_reads = 2;
        if (!e2[0]) exp_err = 3;
        else begin
          exp_err = 0; exp_pa = {e2[47:12], va[11:0]};
          ltr_ok = 1'b1; ltr_vpn = va[47:12]; ltr_ppn = e2[47:12];
        end
      end
    end
    etag = (exp_err == 1) ? "R2" : (exp_err == 2) ? "R3" : "R4";
    rtag = hit ? "R8" : etag;

    @(negedge clk);
    rd_base = rd_count; hold_err = 1'b0; ovl_err = 1'b0;
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready || resp_valid;
    cyc = 1;
    while (!resp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    reads = rd_count - rd_base;
    chk(resp_valid, "R6", "response arrives", 64'(resp_valid), 64'd1);
    chk(busy_ok && !req_ready, "R6", "req_ready low while busy", 64'(req_ready), 64'd0);
    chk(int'(resp_err) == exp_err, etag, "fault code", 64'(resp_err), 64'(exp_err));
    chk(resp_pa == exp_pa, (exp_err != 0) ? "R7" : "R1", "physical address", 64'(resp_pa), 64'(exp_pa));
    chk(reads == exp_reads, rtag, "memory reads", 64'(reads), 64'(exp_reads));
    if (exp_reads >= 1) chk(addr_log[0] == fa, "R3", "flat entry address", 64'(addr_log[0]), 64'(fa));
    if (exp_reads == 2) chk(addr_log[1] == sa, "R4", "page entry address", 64'(addr_log[1]), 64'(sa));
    if (hit) chk(cyc == 1, "R8", "hit latency", 64'(cyc), 64'd1);
    chk(!hold_err && !ovl_err, "R5", "request hold / single outstanding",
        64'({hold_err, ovl_err}), 64'd0);
    @(negedge clk);
    chk(!resp_valid && req_ready, "R6", "pulse ends and idle",
        64'({resp_valid, req_ready}), 64'b01);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [47:0] va;
    logic [47:0] keep_va;
    for (int i = 0; i < 128; i++) begin rgn_ok[i] = 1'b0; rgn_bs[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk(req_ready == 1'b1, "R10", "req_ready after reset", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0, "R10", "resp_valid after reset", 64'(resp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R10", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    // R10: every region invalid -> region fault, no read
    run({7'd0, 20'h12345, 9'h0AB, 12'h321});
    run({7'd127, 20'hFFFFF, 9'h1FF, 12'hFFF});

    // program all regions, one in four left invalid
    for (int r = 0; r < 128; r++)
      wr_rgn(r, (r % 4) != 3, 48'(r) << 33);

    // sweep: one page per region, then same page with a new offset (R8)
    for (int r = 0; r < 128; r++) begin
      va = {7'(r), 20'(r * 7919 + 5), 9'(r * 37), 12'(r * 41)};
      run(va);
      run({va[47:12], va[11:0] ^ 12'h5A5});
    end

    // field extremes in valid regions (R1)
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 8; k++) begin
        va = {7'(r), k[0] ? 20'hFFFFF : 20'h00000,
              k[1] ? 9'h1FF : 9'h000, k[2] ? 12'hFFF : 12'h000};
        run(va);
      end

    // R9: a faulting walk keeps the stored translation
    if (!ltr_ok) run({7'd0, 20'd1, 9'd0, 12'd0});
    keep_va = {ltr_vpn, 12'h0C3};
    run({7'd3, 20'h00042, 9'h011, 12'h222});
    run(keep_va);
    chk(ltr_ok && keep_va[47:12] == ltr_vpn, "R9", "translation kept after fault",
        64'(ltr_ok), 64'd1);

    // R9: a region write empties it; the same page walks again
    wr_rgn(5, 1'b1, 48'd5 << 33);
    run(keep_va);
    // R2: invalidating the page's region makes it fault without a read
    wr_rgn(int'(keep_va[47:41]), 1'b0, 48'(keep_va[47:41]) << 33);
    run(keep_va);
    // R2: re-enable with a new base; the walk follows the new base
    wr_rgn(int'(keep_va[47:41]), 1'b1, (48'(keep_va[47:41]) << 33) + 48'h1000);
    run(keep_va);
    run({keep_va[47:12], 12'hFFF});

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule